// File: doc/BRIEF.md
# Port Expander Serial Slave with Command Pointer

This block is the serial front end of a 16-bit port expander. It watches the open-drain SCL and SDA wires through a fast system clock and decodes START, STOP, address, command and data bytes. When it is addressed it acknowledges by pulling SDA low. For a write, the first byte after the address is a command. Its low three bits load a write-only pointer, and later bytes go to the register that the pointer selects. For a read, bytes are fetched from the register that the pointer selects and shifted out MSB first.

The register bank sits outside this block. The block reaches it over a plain strobe interface. `reg_sel` always shows the pointer. A one-cycle `reg_wr` pulse carries a received byte on `reg_wdata`. A one-cycle `reg_rd` pulse samples `reg_rdata`, which the bank supplies combinationally. After each data byte the low pointer bit flips, so a burst alternates between the two halves of a register pair.

Top module: `expander_i2c_slave`

## Requirements
- R1: After reset, and until a START is seen, SDA is released and neither `reg_wr` nor `reg_rd` pulses. Bytes clocked without a START get no acknowledge.
- R2: The first byte after a START is compared MSB first. Its bits 7:1 must equal {4'b0100, `strap_addr`}. On a match the block pulls SDA low for the ninth clock.
- R3: On an address mismatch the block leaves SDA released for the rest of the transfer. It gives no acknowledge and no register strobe until the next START or STOP.
- R4: Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read.
- R5: In a write, the first byte after the address is a command and is acknowledged. Its bits 2:0 load the pointer and bits 7:3 are ignored. It causes no `reg_wr`.
- R6: Every later written byte is acknowledged. It gives exactly one `reg_wr` pulse, with `reg_wdata` equal to the byte and `reg_sel` equal to the pointer.
- R7: After each data byte, written or read, pointer bit 0 is inverted and the upper pointer bits are kept.
- R8: In a read, `reg_rd` pulses with `reg_sel` equal to the pointer, and the fetched byte is driven on SDA MSB first. Another byte follows while the master acknowledges. A master NACK ends the read with SDA released.
- R9: A repeated START begins a new address phase and keeps the pointer. A command write followed by a repeated START and a read returns the selected register.
- R10: A STOP at any point, even inside a byte, returns the block to idle with SDA released. No partial byte is written, and the pointer keeps its value.
- R11: The block changes SDA only while SCL is low, except when a START or STOP arrives. Transfers work at a 400 kHz SCL with a 100 MHz sampling clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Level of the SCL wire |
| sda_in | input | 1 | Level of the SDA wire |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_addr | input | STRAP_W | Strap pins forming the low address bits |
| reg_sel | output | SEL_W | Current pointer, selects the register |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to be written |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Selected register contents, combinational |

## Verification
The bench builds the block with its defaults: fixed address bits 4'b0100, three strap bits, a three-bit pointer and a two-stage synchroniser. SCL runs at about 400 kHz, 252 sampling cycles per bit, so the two- to three-cycle synchroniser lag sits well inside each SCL low phase, as a real fast-mode bus needs. Because the strap inputs change between transfers, both a matching and a stale address are exercised. The three-bit pointer lets the burst tests reach both the pointer toggle across a register pair and the masking of the upper command bits.

// File: rtl/expander_i2c_pkg.sv
package expander_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } bus_state_t;

    // Synchronised line levels and bus events, one cycle wide each.
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    function automatic logic byte_full(input logic [CNT_W-1:0] cnt);
        return cnt == CNT_W'(BYTE_W);
    endfunction

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cnt);
        return (&cnt) ? cnt : cnt + 1'b1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import expander_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_raw,
    input  logic      sda_raw,
    output line_evt_t evt
);

    logic [1:0] chain [STAGES];
    logic [1:0] prev_q;
    logic [1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            chain[0] <= {scl_raw, sda_raw};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[STAGES-1];
        end
    end

    assign cur = chain[STAGES-1];

    always_comb begin
        evt.scl      = cur[1];
        evt.sda      = cur[0];
        evt.scl_rise = cur[1] & ~prev_q[1];
        evt.scl_fall = ~cur[1] & prev_q[1];
        evt.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
        evt.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
    end

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
    import expander_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              scl_rise,
    input  logic              sda_s,
    input  logic              tx_load,
    input  logic              tx_shift,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_bit,
    output logic              full
);

    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] tx_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (scl_rise) rx_q <= {rx_q[BYTE_W-2:0], sda_s};
            if (cnt_clr)       cnt_q <= '0;
            else if (scl_rise) cnt_q <= cnt_step(cnt_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           tx_q <= '1;
        else if (tx_load)  tx_q <= tx_byte;
        else if (tx_shift) tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
    end

    assign rx_byte = rx_q;
    assign tx_bit  = tx_q[BYTE_W-1];
    assign full    = byte_full(cnt_q);

endmodule

// File: rtl/i2c_reg_pointer.sv
module i2c_reg_pointer #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] load_val,
    input  logic             flip,
    output logic [SEL_W-1:0] ptr
);

    logic [SEL_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (load) ptr_q <= load_val;
        else if (flip) ptr_q <= {ptr_q[SEL_W-1:1], ~ptr_q[0]};
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/expander_i2c_slave.sv
module expander_i2c_slave
    import expander_i2c_pkg::*;
#(
    parameter int               FIXED_W     = 4,
    parameter logic [FIXED_W-1:0] FIXED_ADDR = 4'b0100,
    parameter int               STRAP_W     = 3,
    parameter int               SEL_W       = 3,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_drive_low,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic [SEL_W-1:0]   reg_sel,
    output logic               reg_wr,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_rd,
    input  logic [BYTE_W-1:0]  reg_rdata
);

    localparam int ADDR_W = FIXED_W + STRAP_W;

    line_evt_t         evt;
    logic              scl_sync, sda_sync, rise, fall, start_seen, stop_seen;
    bus_state_t        st_q, st_d;
    logic              ack_q, ack_d, rw_q, rw_d, mack_q, mack_d;
    logic              cnt_clr, tx_load, tx_shift, ptr_load, ptr_flip;
    logic              wr_pulse, rd_pulse;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_bit, full;
    logic [SEL_W-1:0]  ptr;
    logic [ADDR_W-1:0] own_addr;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    assign scl_sync   = evt.scl;
    assign sda_sync   = evt.sda;
    assign rise       = evt.scl_rise;
    assign fall       = evt.scl_fall;
    assign start_seen = evt.start;
    assign stop_seen  = evt.stop;

    i2c_byte_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .scl_rise (rise),
        .sda_s    (sda_sync),
        .tx_load  (tx_load),
        .tx_shift (tx_shift),
        .tx_byte  (reg_rdata),
        .rx_byte  (rx_byte),
        .tx_bit   (tx_bit),
        .full     (full)
    );

    i2c_reg_pointer #(.SEL_W(SEL_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (rx_byte[SEL_W-1:0]),
        .flip     (ptr_flip),
        .ptr      (ptr)
    );

    assign own_addr = {FIXED_ADDR, strap_addr};

    always_comb begin
        st_d     = st_q;
        ack_d    = ack_q;
        rw_d     = rw_q;
        mack_d   = mack_q;
        cnt_clr  = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        ptr_load = 1'b0;
        ptr_flip = 1'b0;
        wr_pulse = 1'b0;
        rd_pulse = 1'b0;
        if (stop_seen) begin
            st_d  = ST_IDLE;
            ack_d = 1'b0;
        end else if (start_seen) begin
            st_d    = ST_ADDR;
            ack_d   = 1'b0;
            cnt_clr = 1'b1;
        end else begin
            unique case (st_q)
                ST_ADDR: if (fall && full) begin
                    if (rx_byte[BYTE_W-1:1] == own_addr) begin
                        st_d  = ST_ADDR_ACK;
                        ack_d = 1'b1;
                        rw_d  = rx_byte[0];
                    end else begin
                        st_d = ST_SKIP;
                    end
                end
                ST_ADDR_ACK: if (fall) begin
                    ack_d   = 1'b0;
                    cnt_clr = 1'b1;
                    if (rw_q) begin
                        st_d     = ST_RD;
                        rd_pulse = 1'b1;
                        tx_load  = 1'b1;
                        ptr_flip = 1'b1;
                    end else begin
                        st_d = ST_CMD;
                    end
                end
                ST_CMD: if (fall && full) begin
                    ptr_load = 1'b1;
                    ack_d    = 1'b1;
                    st_d     = ST_CMD_ACK;
                end
                ST_CMD_ACK, ST_WR_ACK: if (fall) begin
                    ack_d   = 1'b0;
                    cnt_clr = 1'b1;
                    st_d    = ST_WR;
                end
                ST_WR: if (fall && full) begin
                    wr_pulse = 1'b1;
                    ptr_flip = 1'b1;
                    ack_d    = 1'b1;
                    st_d     = ST_WR_ACK;
                end
                ST_RD: if (fall) begin
                    if (full) st_d = ST_RD_ACK;
                    else      tx_shift = 1'b1;
                end
                ST_RD_ACK: begin
                    if (rise) mack_d = ~sda_sync;
                    if (fall) begin
                        cnt_clr = 1'b1;
                        if (mack_q) begin
                            st_d     = ST_RD;
                            rd_pulse = 1'b1;
                            tx_load  = 1'b1;
                            ptr_flip = 1'b1;
                        end else begin
                            st_d = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ack_q  <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ack_q  <= ack_d;
            rw_q   <= rw_d;
            mack_q <= mack_d;
        end
    end

    assign sda_drive_low = ack_q | ((st_q == ST_RD) & ~tx_bit);
    assign reg_sel       = ptr;
    assign reg_wr        = wr_pulse;
    assign reg_wdata     = rx_byte;
    assign reg_rd        = rd_pulse;

endmodule

// File: rtl/expander_i2c_slave_checker.sv
module expander_i2c_slave_checker
    import expander_i2c_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_drive_low,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [BYTE_W-1:0] reg_rdata,
    input logic              scl_sync,
    input logic              start_seen,
    input logic              stop_seen
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_drive_low && !reg_wr && !reg_rd));

    assert_write_acked_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> sda_drive_low);

    assert_ptr_flip_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr || reg_rd) |=>
            (reg_sel == {$past(reg_sel[SEL_W-1:1]), ~$past(reg_sel[0])}));

    assert_read_msb_R8: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (sda_drive_low == !$past(reg_rdata[BYTE_W-1])));

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_drive_low);

    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_drive_low) && !$past(stop_seen) && !$past(start_seen)) |-> !scl_sync);

endmodule

bind expander_i2c_slave expander_i2c_slave_checker #(.SEL_W(SEL_W)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .sda_drive_low (sda_drive_low),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_sel       (reg_sel),
    .reg_rdata     (reg_rdata),
    .scl_sync      (scl_sync),
    .start_seen    (start_seen),
    .stop_seen     (stop_seen)
);

// File: tb/expander_i2c_slave_bench.sv
module expander_i2c_slave_bench;

    localparam int Q = 63;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_line;
    logic       sda_drive_low, reg_wr, reg_rd;
    logic [2:0] reg_sel;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] bank [8];
    logic [7:0] exp_bank [8];
    logic [10:0] exp_q [$];
    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    assign sda_line  = ~(m_low | sda_drive_low);
    assign reg_rdata = bank[reg_sel];

    expander_i2c_slave u_expander_i2c_slave (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .strap_addr    (strap),
        .reg_sel       (reg_sel),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rd        (reg_rd),
        .reg_rdata     (reg_rdata)
    );

    function automatic logic [7:0] seed_val(input int i);
        return 8'h5A ^ 8'(i * 8'h13);
    endfunction

    always @(posedge clk) begin
        if (rst) for (int i = 0; i < 8; i++) bank[i] <= seed_val(i);
        else if (reg_wr) bank[reg_sel] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes as the design strobes them.
    always @(negedge clk) begin
        if (!rst && reg_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected reg_wr", {21'd0, reg_sel, reg_wdata}, 32'd0);
            end else begin
                logic [10:0] item;
                item = exp_q.pop_front();
                chk({reg_sel, reg_wdata} == item, "R6 write item",
                    {21'd0, reg_sel, reg_wdata}, {21'd0, item});
            end
        end
    end

    task automatic push_wr(input logic [2:0] sel, input logic [7:0] d);
        exp_q.push_back({sel, d});
        exp_bank[sel] = d;
    endtask

    task automatic qwait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic b_start;
        m_low = 1'b0; qwait(1);
        m_scl = 1'b1; qwait(1);
        m_low = 1'b1; qwait(1);
        m_scl = 1'b0; qwait(1);
    endtask

    task automatic b_stop;
        m_low = 1'b1; qwait(1);
        m_scl = 1'b1; qwait(1);
        m_low = 1'b0; qwait(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; qwait(1);
            m_scl = 1'b1;  qwait(2);
            m_scl = 1'b0;  qwait(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 1'b0; qwait(1);
        m_scl = 1'b1; qwait(1);
        ack = ~sda_line; qwait(1);
        m_scl = 1'b0; qwait(1);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait(1);
            m_scl = 1'b1; qwait(1);
            b[i] = sda_line; qwait(1);
            m_scl = 1'b0;
        end
        qwait(1);
        m_low = give_ack; qwait(1);
        m_scl = 1'b1; qwait(2);
        m_scl = 1'b0; qwait(1);
        m_low = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        for (int i = 0; i < 8; i++) exp_bank[i] = seed_val(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sda_drive_low && !reg_wr && !reg_rd, "R1 reset outputs",
            {sda_drive_low, reg_wr, reg_rd}, 0);

        // Write burst: command selects 2, data alternates 2,3 (R2 R4 R5 R6 R7)
        b_start();
        send_byte(8'h4A, ack); chk(ack, "R2 address ack (write)", ack, 1);
        send_byte(8'h02, ack); chk(ack, "R5 command ack", ack, 1);
        push_wr(3'd2, 8'hA5);
        send_byte(8'hA5, ack); chk(ack, "R6 data ack", ack, 1);
        push_wr(3'd3, 8'h3C);
        send_byte(8'h3C, ack); chk(ack, "R7 second data ack", ack, 1);
        b_stop();
        chk(exp_q.size() == 0, "R7 writes to 2 then 3", exp_q.size(), 0);

        // Upper command bits ignored: 0xFE selects 6 (R5 R7)
        b_start();
        send_byte(8'h4A, ack);
        send_byte(8'hFE, ack); chk(ack, "R5 masked command ack", ack, 1);
        push_wr(3'd6, 8'h11); send_byte(8'h11, ack);
        push_wr(3'd7, 8'h22); send_byte(8'h22, ack);
        push_wr(3'd6, 8'h33); send_byte(8'h33, ack);
        b_stop();
        chk(exp_q.size() == 0, "R5 writes 6,7,6", exp_q.size(), 0);

        // Address mismatches (R3)
        b_start();
        send_byte(8'h4C, ack); chk(!ack, "R3 wrong strap bits nack", ack, 0);
        send_byte(8'h01, ack); chk(!ack, "R3 later byte ignored", ack, 0);
        send_byte(8'h77, ack); chk(!ack, "R3 data byte ignored", ack, 0);
        b_stop();
        b_start();
        send_byte(8'hCA, ack); chk(!ack, "R3 wrong fixed bits nack", ack, 0);
        b_stop();

        // Command then repeated START read burst (R8 R9 R4)
        b_start();
        send_byte(8'h4A, ack);
        send_byte(8'h06, ack);
        b_start();
        send_byte(8'h4B, ack); chk(ack, "R4 read address ack", ack, 1);
        recv_byte(rb, 1'b1); chk(rb == exp_bank[6], "R9 read after restart", rb, exp_bank[6]);
        recv_byte(rb, 1'b1); chk(rb == exp_bank[7], "R8 burst second byte", rb, exp_bank[7]);
        recv_byte(rb, 1'b0); chk(rb == exp_bank[6], "R11 burst third byte", rb, exp_bank[6]);
        qwait(1);
        chk(!sda_drive_low, "R8 released after nack", sda_drive_low, 0);
        b_stop();

        // Read without command continues from pointer 7 (R7)
        b_start();
        send_byte(8'h4B, ack);
        recv_byte(rb, 1'b0); chk(rb == exp_bank[7], "R7 read-side pointer flip", rb, exp_bank[7]);
        b_stop();

        // STOP inside a data byte (R10)
        b_start();
        send_byte(8'h4A, ack);
        send_byte(8'h02, ack);
        send_bits(8'hFF, 3);
        b_stop();
        qwait(2);
        chk(!sda_drive_low, "R10 SDA released after stop", sda_drive_low, 0);
        b_start();
        send_byte(8'h4B, ack);
        recv_byte(rb, 1'b0); chk(rb == exp_bank[2], "R10 pointer kept, no partial write", rb, exp_bank[2]);
        b_stop();

        // Strap change (R2)
        strap = 3'b010;
        b_start();
        send_byte(8'h4A, ack); chk(!ack, "R2 old address now nack", ack, 0);
        b_stop();
        b_start();
        send_byte(8'h44, ack); chk(ack, "R2 new strap address ack", ack, 1);
        send_byte(8'h07, ack);
        push_wr(3'd7, 8'h5E); send_byte(8'h5E, ack);
        b_stop();

        // Byte with no START (R1)
        m_scl = 1'b0; qwait(1);
        send_byte(8'h44, ack); chk(!ack, "R1 no ack without START", ack, 0);
        m_scl = 1'b1; qwait(2);

        chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
        chk(bank[7] == 8'h5E, "R6 register updated", bank[7], 8'h5E);
        summary();
        $finish;
    end

endmodule